// File: doc/BRIEF.md
# Partial-Tag Way-Filtered Cache Lookup

This block is the lookup path of an eight-way set-associative tag store that avoids waking every way on every access. Next to the full tag array sits a narrow side array that keeps, for each way of each set, a valid bit and only the lowest `PTAG_W` bits of the stored tag. A lookup first compares these short tags with the same low bits of the request tag. A way is enabled only if it is valid and its short tag agrees. Only enabled ways take part in the full tag compare, and only they would read the data array. A way with a mismatching short tag is never touched. The partial compare and the gated full compare share one lookup cycle, so the hit latency is the same as a lookup with no filter.

The same structure serves a private first-level cache, a shared second-level cache or a coherence directory cache. Fills write the full tag and its short copy together. Invalidations clear the valid bit. Every lookup returns a registered response one cycle later: the hit flag, the binary hit way, the per-way enable vector and the number of enabled ways. The count lets a checker compare the activity against a full-parallel lookup, which always enables all ways.

Top module: `tf_lookup`

## Requirements
- R1: After reset every entry is invalid and all response outputs are zero. A lookup that follows reset returns a miss with an all-zero enable vector.
- R2: A lookup presented on `lkp_valid` at a rising edge gives `rsp_valid`=1 after that edge, which is one cycle of latency. In a cycle after an edge with no lookup, `rsp_valid`, `rsp_hit`, `rsp_way`, `rsp_way_en` and `rsp_en_cnt` are all zero.
- R3: Bit w of `rsp_way_en` is 1 exactly when way w of the indexed set is valid and the low `PTAG_W` bits of its stored tag equal the low `PTAG_W` bits of `lkp_tag`.
- R4: `rsp_hit` is 1 exactly when an enabled way holds a full tag equal to `lkp_tag`. `rsp_way` then gives that way's index as an unsigned binary number. On a miss, `rsp_way` is 0.
- R5: When no way passes the filter, the response is a miss with `rsp_way_en` zero and `rsp_en_cnt` zero.
- R6: `rsp_en_cnt` equals the number of ones in `rsp_way_en`. It lies between 0 and `WAYS`.
- R7: A fill writes the full tag and the short tag of way `fill_way` in set `fill_set` and sets its valid bit. Lookups see the new entry from the next cycle onward. A lookup in the same cycle as the fill sees the old contents.
- R8: An invalidation clears the valid bit of the chosen entry, so that entry never again enables until it is refilled. If a fill and an invalidation name the same entry in the same cycle, the entry ends up invalid.
- R9: When several ways share the request's short tag, all of them are enabled and fully compared, and only the way whose full tag matches reports the hit. The design requires that the full tags of the valid ways in one set stay unique. At most one full match may occur in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_valid | input | 1 | Lookup request strobe |
| lkp_set | input | SET_W | Set index of the lookup |
| lkp_tag | input | TAG_W | Full tag of the lookup |
| fill_valid | input | 1 | Fill (tag write) strobe |
| fill_set | input | SET_W | Set index of the fill |
| fill_way | input | WAY_W | Victim way of the fill |
| fill_tag | input | TAG_W | Tag written by the fill |
| inv_valid | input | 1 | Invalidation strobe |
| inv_set | input | SET_W | Set index of the invalidation |
| inv_way | input | WAY_W | Way to invalidate |
| rsp_valid | output | 1 | Response present, one cycle after a lookup |
| rsp_hit | output | 1 | Full tag hit |
| rsp_way | output | WAY_W | Binary index of the hit way |
| rsp_way_en | output | WAYS | Per-way enable for the full tag and data arrays |
| rsp_en_cnt | output | CNT_W | Number of ways enabled by the filter |

## Verification
Every lookup result is registered once, so each response field is due in the cycle right after the edge that sampled the request. Fill and invalidation effects show up in a lookup issued one cycle after the write. The bench drives each operation at a falling edge. It computes the expected response from its own model of the arrays before it updates that model with the same cycle's writes. It then compares the outputs at the next falling edge. This order also covers a lookup that meets a fill to the same entry. Short tags are drawn from a small range, so partial collisions with several enabled ways, and misses with no enabled way, occur often.

// File: rtl/tf_pkg.sv
package tf_pkg;
    localparam int unsigned TF_WAYS   = 8;
    localparam int unsigned TF_SETS   = 16;
    localparam int unsigned TF_TAG_W  = 20;
    localparam int unsigned TF_PTAG_W = 4;
endpackage

// File: rtl/tf_side_array.sv
module tf_side_array #(
    parameter int unsigned WAYS   = 8,
    parameter int unsigned SETS   = 16,
    parameter int unsigned PTAG_W = 4,
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [SET_W-1:0]  lkp_set,
    input  logic [PTAG_W-1:0] lkp_ptag,
    input  logic              fill_valid,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [PTAG_W-1:0] fill_ptag,
    input  logic              inv_valid,
    input  logic [SET_W-1:0]  inv_set,
    input  logic [WAY_W-1:0]  inv_way,
    output logic [WAYS-1:0]   way_en
);
    logic [SETS-1:0][WAYS-1:0]             vld_d, vld_q;
    logic [SETS-1:0][WAYS-1:0][PTAG_W-1:0] ptag_d, ptag_q;

    // screen: valid and short tag agrees
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            way_en[w] = lkp_valid && vld_q[lkp_set][w] &&
                        (ptag_q[lkp_set][w] == lkp_ptag);
        end
    end

    // next state: fill first, invalidation overrides
    always_comb begin
        vld_d  = vld_q;
        ptag_d = ptag_q;
        if (fill_valid) begin
            vld_d[fill_set][fill_way]  = 1'b1;
            ptag_d[fill_set][fill_way] = fill_ptag;
        end
        if (inv_valid) begin
            vld_d[inv_set][inv_way] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        ptag_q <= ptag_d;
    end
endmodule

// File: rtl/tf_tag_array.sv
module tf_tag_array #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned SETS  = 16,
    parameter int unsigned TAG_W = 20,
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic [SET_W-1:0] lkp_set,
    input  logic [TAG_W-1:0] lkp_tag,
    input  logic [WAYS-1:0]  way_en,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    output logic [WAYS-1:0]  match
);
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_d, tag_q;

    // full compare only in ways the screen let through
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_en[g] && (tag_q[lkp_set][g] == lkp_tag);
    end

    always_comb begin
        tag_d = tag_q;
        if (fill_valid) tag_d[fill_set][fill_way] = fill_tag;
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
    end
endmodule

// File: rtl/tf_resp_enc.sv
module tf_resp_enc #(
    parameter int unsigned WAYS = 8,
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned CNT_W = $clog2(WAYS + 1)
) (
    input  logic [WAYS-1:0]  match,
    input  logic [WAYS-1:0]  way_en,
    output logic             hit,
    output logic [WAY_W-1:0] way,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        hit = |match;
        way = '0;
        cnt = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WAY_W'(w);
        end
        for (int w = 0; w < WAYS; w++) begin
            cnt = cnt + CNT_W'(way_en[w]);
        end
    end
endmodule

// File: rtl/tf_lookup.sv
module tf_lookup
    import tf_pkg::*;
#(
    parameter int unsigned WAYS   = TF_WAYS,
    parameter int unsigned SETS   = TF_SETS,
    parameter int unsigned TAG_W  = TF_TAG_W,
    parameter int unsigned PTAG_W = TF_PTAG_W,
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned CNT_W = $clog2(WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_valid,
    input  logic [SET_W-1:0] lkp_set,
    input  logic [TAG_W-1:0] lkp_tag,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             inv_valid,
    input  logic [SET_W-1:0] inv_set,
    input  logic [WAY_W-1:0] inv_way,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [WAY_W-1:0] rsp_way,
    output logic [WAYS-1:0]  rsp_way_en,
    output logic [CNT_W-1:0] rsp_en_cnt
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [WAY_W-1:0] way;
        logic [WAYS-1:0]  en;
        logic [CNT_W-1:0] cnt;
    } rsp_t;

    logic [WAYS-1:0]  way_en;
    logic [WAYS-1:0]  full_match;
    logic             hit_c;
    logic [WAY_W-1:0] way_c;
    logic [CNT_W-1:0] cnt_c;
    rsp_t             rsp_d, rsp_q;

    tf_side_array #(.WAYS(WAYS), .SETS(SETS), .PTAG_W(PTAG_W)) i_side (
        .clk       (clk),
        .rst_n     (rst_n),
        .lkp_valid (lkp_valid),
        .lkp_set   (lkp_set),
        .lkp_ptag  (lkp_tag[PTAG_W-1:0]),
        .fill_valid(fill_valid),
        .fill_set  (fill_set),
        .fill_way  (fill_way),
        .fill_ptag (fill_tag[PTAG_W-1:0]),
        .inv_valid (inv_valid),
        .inv_set   (inv_set),
        .inv_way   (inv_way),
        .way_en    (way_en)
    );

    tf_tag_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) i_tags (
        .clk       (clk),
        .lkp_set   (lkp_set),
        .lkp_tag   (lkp_tag),
        .way_en    (way_en),
        .fill_valid(fill_valid),
        .fill_set  (fill_set),
        .fill_way  (fill_way),
        .fill_tag  (fill_tag),
        .match     (full_match)
    );

    tf_resp_enc #(.WAYS(WAYS)) i_enc (
        .match (full_match),
        .way_en(way_en),
        .hit   (hit_c),
        .way   (way_c),
        .cnt   (cnt_c)
    );

    always_comb begin
        rsp_d = '0;
        if (lkp_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.hit   = hit_c;
            rsp_d.way   = way_c;
            rsp_d.en    = way_en;
            rsp_d.cnt   = cnt_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_way    = rsp_q.way;
    assign rsp_way_en = rsp_q.en;
    assign rsp_en_cnt = rsp_q.cnt;
endmodule

// File: rtl/tf_lookup_chk.sv
module tf_lookup_chk #(
    parameter int unsigned WAYS = 8,
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned CNT_W = $clog2(WAYS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lkp_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way,
    input logic [WAYS-1:0]  rsp_way_en,
    input logic [CNT_W-1:0] rsp_en_cnt,
    input logic [WAYS-1:0]  full_match
);
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_way == '0 && rsp_way_en == '0 && rsp_en_cnt == '0));
    assert_hit_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_way_en[rsp_way]);
    assert_empty_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_way_en == '0) |-> (!rsp_hit && rsp_en_cnt == '0));
    assert_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_en_cnt == CNT_W'($countones(rsp_way_en)));
    assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(full_match));
endmodule

bind tf_lookup tf_lookup_chk #(.WAYS(WAYS)) i_tf_lookup_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way),
    .rsp_way_en(rsp_way_en),
    .rsp_en_cnt(rsp_en_cnt),
    .full_match(full_match)
);

// File: tb/test_tf_lookup.sv
module test_tf_lookup;
    localparam int WAYS = 8, SETS = 16, TAG_W = 20, PTAG_W = 4;
    localparam int SET_W = 4, WAY_W = 3, CNT_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lkp_valid = 0, fill_valid = 0, inv_valid = 0;
    logic [SET_W-1:0] lkp_set = '0, fill_set = '0, inv_set = '0;
    logic [WAY_W-1:0] fill_way = '0, inv_way = '0;
    logic [TAG_W-1:0] lkp_tag = '0, fill_tag = '0;
    logic rsp_valid, rsp_hit;
    logic [WAY_W-1:0] rsp_way;
    logic [WAYS-1:0] rsp_way_en;
    logic [CNT_W-1:0] rsp_en_cnt;

    int checks = 0, errors = 0;
    bit done = 0;
    logic             m_vld [SETS][WAYS];
    logic [TAG_W-1:0] m_tag [SETS][WAYS];
    logic             e_valid, e_hit;
    logic [WAY_W-1:0] e_way;
    logic [WAYS-1:0]  e_en;
    logic [CNT_W-1:0] e_cnt;

    always #10 clk = ~clk;

    tf_lookup i_tf_lookup (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected response from the model, before this cycle's writes
    task automatic expect_rsp(input logic lv, input logic [SET_W-1:0] s, input logic [TAG_W-1:0] t);
        e_valid = lv; e_hit = 0; e_way = '0; e_en = '0; e_cnt = '0;
        if (lv) begin
            for (int w = 0; w < WAYS; w++) begin
                if (m_vld[s][w] && m_tag[s][w][PTAG_W-1:0] == t[PTAG_W-1:0]) begin
                    e_en[w] = 1'b1;
                    e_cnt++;
                    if (m_tag[s][w] == t) begin e_hit = 1; e_way = WAY_W'(w); end
                end
            end
        end
    endtask

    function automatic bit dup_tag(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w0, input logic [TAG_W-1:0] t);
        for (int w = 0; w < WAYS; w++)
            if (w != int'(w0) && m_vld[s][w] && m_tag[s][w] == t) return 1;
        return 0;
    endfunction

    task automatic op(input logic lv, input logic [SET_W-1:0] ls, input logic [TAG_W-1:0] lt,
                      input logic fv, input logic [SET_W-1:0] fs, input logic [WAY_W-1:0] fw,
                      input logic [TAG_W-1:0] ft,
                      input logic iv, input logic [SET_W-1:0] is, input logic [WAY_W-1:0] iw);
        if (fv && dup_tag(fs, fw, ft)) fv = 0;
        expect_rsp(lv, ls, lt);
        lkp_valid = lv; lkp_set = ls; lkp_tag = lt;
        fill_valid = fv; fill_set = fs; fill_way = fw; fill_tag = ft;
        inv_valid = iv; inv_set = is; inv_way = iw;
        if (fv) begin m_vld[fs][fw] = 1; m_tag[fs][fw] = ft; end
        if (iv) m_vld[is][iw] = 0;
        @(negedge clk);
        chk("R2 rsp_valid", 32'(rsp_valid), 32'(e_valid));
        chk("R3 rsp_way_en", 32'(rsp_way_en), 32'(e_en));
        chk("R4 rsp_hit", 32'(rsp_hit), 32'(e_hit));
        chk("R4 rsp_way", 32'(rsp_way), 32'(e_way));
        chk("R6 rsp_en_cnt", 32'(rsp_en_cnt), 32'(e_cnt));
    endtask

    task automatic fill(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w, input logic [TAG_W-1:0] t);
        op(0, '0, '0, 1, s, w, t, 0, '0, '0);
    endtask

    task automatic look(input logic [SET_W-1:0] s, input logic [TAG_W-1:0] t);
        op(1, s, t, 0, '0, '0, '0, 0, '0, '0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin m_vld[s][w] = 0; m_tag[s][w] = '0; end
        @(negedge clk); @(negedge clk);
        // R1: outputs at reset
        chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
        chk("R1 reset rsp_way_en", 32'(rsp_way_en), 0);
        rst_n = 1;
        @(negedge clk);
        // R1/R5: lookup after reset misses with no enable
        look(4'd3, 20'h00000);
        chk("R5 empty miss", 32'(rsp_hit), 0);
        // R9: three ways sharing short tag 5
        fill(4'd2, 3'd1, 20'h00105);
        fill(4'd2, 3'd4, 20'h00205);
        fill(4'd2, 3'd6, 20'h00305);
        fill(4'd2, 3'd7, 20'h00306);
        look(4'd2, 20'h00205);
        chk("R9 three candidates one hit", 32'({rsp_hit, rsp_way, rsp_en_cnt}), 32'({1'b1, 3'd4, 4'd3}));
        look(4'd2, 20'h00405);
        chk("R9 candidates but miss", 32'({rsp_hit, rsp_way_en}), 32'({1'b0, 8'b0101_0010}));
        // R5: no short tag agrees
        look(4'd2, 20'h00309);
        chk("R5 no candidate", 32'({rsp_hit, rsp_way_en, rsp_en_cnt}), 0);
        // R7: lookup in same cycle as fill sees old contents, next cycle sees new
        op(1, 4'd5, 20'h0ABC3, 1, 4'd5, 3'd0, 20'h0ABC3, 0, '0, '0);
        chk("R7 same-cycle old contents", 32'(rsp_hit), 0);
        look(4'd5, 20'h0ABC3);
        chk("R7 visible next cycle", 32'({rsp_hit, rsp_way}), 32'({1'b1, 3'd0}));
        // R8: invalidate, then fill+inv on same entry ends invalid
        op(0, '0, '0, 0, '0, '0, '0, 1, 4'd2, 3'd4);
        look(4'd2, 20'h00205);
        chk("R8 invalidated way", 32'({rsp_hit, rsp_en_cnt}), 32'({1'b0, 4'd2}));
        op(0, '0, '0, 1, 4'd2, 3'd4, 20'h00205, 1, 4'd2, 3'd4);
        look(4'd2, 20'h00205);
        chk("R8 fill and inv same entry", 32'(rsp_way_en[4]), 0);
        // R2: idle cycle gives quiet outputs
        op(0, '0, '0, 0, '0, '0, '0, 0, '0, '0);
        chk("R2 idle quiet", 32'({rsp_valid, rsp_hit, rsp_way_en, rsp_en_cnt}), 0);
        // random mix, short tags from a small range to force collisions
        for (int i = 0; i < 4000; i++) begin
            logic [SET_W-1:0] ls, fs, is;
            logic [WAY_W-1:0] fw, iw, pw;
            logic [TAG_W-1:0] lt, ft;
            ls = SET_W'($urandom % 4); fs = SET_W'($urandom % 4); is = SET_W'($urandom % 4);
            fw = WAY_W'($urandom); iw = WAY_W'($urandom); pw = WAY_W'($urandom);
            ft = TAG_W'((($urandom % 6) << PTAG_W) | ($urandom % 3));
            if ($urandom % 2) lt = m_tag[ls][pw];
            else lt = TAG_W'((($urandom % 6) << PTAG_W) | ($urandom % 3));
            op(1'($urandom % 4 != 0), ls, lt, 1'($urandom % 3 == 0), fs, fw, ft,
               1'($urandom % 8 == 0), is, iw);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule